// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a processor datapath that reuses one memory and one ALU across several cycles per instruction. It is a Moore machine: a 4-bit state register plus a fixed control word for each state. Each instruction runs through fetch, decode, and then a short path chosen by its 6-bit opcode. The five supported instruction kinds take between three and five cycles each.

The instruction register in the datapath supplies the opcode. Only the decode state and the address-computation state look at it. Every other state drives its control word and moves on no matter what the opcode holds. The outputs go straight to the datapath: register write enables, memory strobes, and multiplexer selects. The current state is also brought out as a port so that the datapath, or a bench, can observe it.

Top module: `mcfsm_ctrl`

## Requirements
- R1: While rstN is low the state is 0 (fetch), and this takes effect at once, with no clock edge needed. Releasing reset starts sequencing from fetch.
- R2: State 0 asserts memRead, irWrite and pcWrite, with iOrD=0, aluSrcA=0, aluSrcB=01, aluOp=00 and pcSrc=00. The next state is always 1.
- R3: State 1 drives aluSrcA=0, aluSrcB=11, aluOp=00 and no strobes. It then dispatches on the opcode:
  - 100011 (load) or 101011 (store) goes to 2.
  - 000000 (register-register) goes to 6.
  - 000100 (branch-if-equal) goes to 8.
  - 000010 (jump) goes to 9.
- R4: State 2 drives aluSrcA=1, aluSrcB=10, aluOp=00 and no strobes. It goes to 3 for a load opcode and to 5 for a store opcode.
- R5: A load takes 5 cycles (states 0,1,2,3,4):
  - State 3 asserts memRead with iOrD=1 and goes to 4.
  - State 4 asserts regWrite with regDst=0 and memToReg=1, then returns to 0.
- R6: A store takes 4 cycles (0,1,2,5). State 5 asserts memWrite with iOrD=1, then returns to 0.
- R7: A register-register instruction takes 4 cycles (0,1,6,7):
  - State 6 drives aluSrcA=1, aluSrcB=00, aluOp=10 and goes to 7.
  - State 7 asserts regWrite with regDst=1 and memToReg=0, then returns to 0.
- R8: A branch takes 3 cycles (0,1,8). State 8 drives aluSrcA=1, aluSrcB=00, aluOp=01, asserts pcWriteCond with pcSrc=01, then returns to 0.
- R9: A jump takes 3 cycles (0,1,9). State 9 asserts pcWrite with pcSrc=10, then returns to 0.
- R10: An opcode that matches none of the five above sends decode straight back to 0, so the instruction takes 2 cycles. No write strobe (pcWrite, pcWriteCond, memWrite, regWrite) is asserted during it.
- R11: In every state, each strobe or select that the state's description does not name is 0. memRead and memWrite are never high together.
- R12: The opcode has no effect in states 0 and 3 to 9. Changing it during those states leaves the state sequence and the control words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| curState | output | 4 | Current state number (0 to 9) |
| pcWrite | output | 1 | Unconditional program-counter write |
| pcWriteCond | output | 1 | Program-counter write qualified by ALU zero |
| iOrD | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| memToReg | output | 1 | Register write data select: 1 = memory data register |
| pcSrc | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| aluOp | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| aluSrcA | output | 1 | ALU A select: 0 = PC, 1 = register A |
| aluSrcB | output | 2 | ALU B select: 00 B, 01 constant 4, 10 immediate, 11 shifted immediate |
| regWrite | output | 1 | Register file write enable |
| regDst | output | 1 | Destination register select: 1 = rd field |

## Verification
Two things can happen in the same cycle: the last state of one instruction, and the opcode changing for the next one. This is also the kind of moment when a careless design would let a stray opcode steer a state that should ignore it. The bench provokes this by driving random opcode values throughout states 3 to 9 and during every completion cycle. Only decode and address computation see the real opcode, which is held steady there. The bench judges each case by comparing the state and the whole control word, cycle by cycle, against a bench model, and by checking the cycle count of each instruction kind. Resets applied in the middle of an instruction check that the asynchronous return to fetch takes priority over whatever transition was pending.

// File: rtl/mcfsm_pkg.sv
package mcfsm_pkg;

  localparam int STATE_W = 4;
  localparam int OP_W    = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE_D = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD_D  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE_D = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ_D   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP_D  = 6'b000010;

  typedef enum logic [STATE_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MEMADR = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_EXEC   = 4'd6,
    S_RTWB   = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } state_t;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iOrD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic [1:0] pcSrc;
    logic [1:0] aluOp;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic       regWrite;
    logic       regDst;
  } ctrlWord_t;

endpackage

// File: rtl/mcfsm_dispatch.sv
module mcfsm_dispatch
  import mcfsm_pkg::*;
#(
  parameter int              OPW       = OP_W,
  parameter logic [OPW-1:0]  OPC_RTYPE = OPC_RTYPE_D,
  parameter logic [OPW-1:0]  OPC_LOAD  = OPC_LOAD_D,
  parameter logic [OPW-1:0]  OPC_STORE = OPC_STORE_D,
  parameter logic [OPW-1:0]  OPC_BEQ   = OPC_BEQ_D,
  parameter logic [OPW-1:0]  OPC_JUMP  = OPC_JUMP_D
) (
  input  state_t         curState,
  input  logic [OPW-1:0] opcode,
  output state_t         nextState
);

  logic isLoad, isStore, isRtype, isBeq, isJump;

  always_comb begin
    isLoad  = (opcode == OPC_LOAD);
    isStore = (opcode == OPC_STORE);
    isRtype = (opcode == OPC_RTYPE);
    isBeq   = (opcode == OPC_BEQ);
    isJump  = (opcode == OPC_JUMP);
  end

  always_comb begin
    nextState = S_FETCH;
    unique case (curState)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        if (isLoad || isStore) nextState = S_MEMADR;
        else if (isRtype)      nextState = S_EXEC;
        else if (isBeq)        nextState = S_BRANCH;
        else if (isJump)       nextState = S_JUMP;
        else                   nextState = S_FETCH;
      end
      S_MEMADR: begin
        if (isLoad)       nextState = S_LDRD;
        else if (isStore) nextState = S_STWR;
        else              nextState = S_FETCH;
      end
      S_LDRD:   nextState = S_LDWB;
      S_EXEC:   nextState = S_RTWB;
      default:  nextState = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcfsm_state_reg.sv
module mcfsm_state_reg
  import mcfsm_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  state_t nextState,
  output state_t curState
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= S_FETCH;
    else       curState <= nextState;
  end

endmodule

// File: rtl/mcfsm_ctrl_decode.sv
module mcfsm_ctrl_decode
  import mcfsm_pkg::*;
(
  input  state_t    curState,
  output ctrlWord_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (curState)
      S_FETCH: begin
        ctrl.memRead = 1'b1;
        ctrl.irWrite = 1'b1;
        ctrl.pcWrite = 1'b1;
        ctrl.aluSrcB = 2'b01;
      end
      S_DECODE: ctrl.aluSrcB = 2'b11;
      S_MEMADR: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluSrcB = 2'b10;
      end
      S_LDRD: begin
        ctrl.memRead = 1'b1;
        ctrl.iOrD    = 1'b1;
      end
      S_LDWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      S_STWR: begin
        ctrl.memWrite = 1'b1;
        ctrl.iOrD     = 1'b1;
      end
      S_EXEC: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluOp   = 2'b10;
      end
      S_RTWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.regDst   = 1'b1;
      end
      S_BRANCH: begin
        ctrl.aluSrcA     = 1'b1;
        ctrl.aluOp       = 2'b01;
        ctrl.pcWriteCond = 1'b1;
        ctrl.pcSrc       = 2'b01;
      end
      S_JUMP: begin
        ctrl.pcWrite = 1'b1;
        ctrl.pcSrc   = 2'b10;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcfsm_ctrl.sv
module mcfsm_ctrl
  import mcfsm_pkg::*;
#(
  parameter int              OPW       = OP_W,
  parameter logic [OPW-1:0]  OPC_RTYPE = OPC_RTYPE_D,
  parameter logic [OPW-1:0]  OPC_LOAD  = OPC_LOAD_D,
  parameter logic [OPW-1:0]  OPC_STORE = OPC_STORE_D,
  parameter logic [OPW-1:0]  OPC_BEQ   = OPC_BEQ_D,
  parameter logic [OPW-1:0]  OPC_JUMP  = OPC_JUMP_D
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPW-1:0]     opcode,
  output logic [STATE_W-1:0] curState,
  output logic               pcWrite,
  output logic               pcWriteCond,
  output logic               iOrD,
  output logic               memRead,
  output logic               memWrite,
  output logic               irWrite,
  output logic               memToReg,
  output logic [1:0]         pcSrc,
  output logic [1:0]         aluOp,
  output logic               aluSrcA,
  output logic [1:0]         aluSrcB,
  output logic               regWrite,
  output logic               regDst
);

  state_t    stateQ;
  state_t    stateD;
  ctrlWord_t ctrl;

  mcfsm_dispatch #(
    .OPW(OPW), .OPC_RTYPE(OPC_RTYPE), .OPC_LOAD(OPC_LOAD),
    .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ), .OPC_JUMP(OPC_JUMP)
  ) dispatch_i (
    .curState (stateQ),
    .opcode   (opcode),
    .nextState(stateD)
  );

  mcfsm_state_reg state_i (
    .clk      (clk),
    .rstN     (rstN),
    .nextState(stateD),
    .curState (stateQ)
  );

  mcfsm_ctrl_decode decode_i (
    .curState(stateQ),
    .ctrl    (ctrl)
  );

  assign curState    = stateQ;
  assign pcWrite     = ctrl.pcWrite;
  assign pcWriteCond = ctrl.pcWriteCond;
  assign iOrD        = ctrl.iOrD;
  assign memRead     = ctrl.memRead;
  assign memWrite    = ctrl.memWrite;
  assign irWrite     = ctrl.irWrite;
  assign memToReg    = ctrl.memToReg;
  assign pcSrc       = ctrl.pcSrc;
  assign aluOp       = ctrl.aluOp;
  assign aluSrcA     = ctrl.aluSrcA;
  assign aluSrcB     = ctrl.aluSrcB;
  assign regWrite    = ctrl.regWrite;
  assign regDst      = ctrl.regDst;

endmodule

// File: rtl/mcfsm_ctrl_chk.sv
module mcfsm_ctrl_chk #(
  parameter int              OPW       = 6,
  parameter logic [OPW-1:0]  OPC_RTYPE = 6'b000000,
  parameter logic [OPW-1:0]  OPC_LOAD  = 6'b100011,
  parameter logic [OPW-1:0]  OPC_STORE = 6'b101011,
  parameter logic [OPW-1:0]  OPC_BEQ   = 6'b000100,
  parameter logic [OPW-1:0]  OPC_JUMP  = 6'b000010
) (
  input logic           clk,
  input logic           rstN,
  input logic [OPW-1:0] opcode,
  input logic [3:0]     curState,
  input logic           pcWrite,
  input logic           pcWriteCond,
  input logic           memRead,
  input logic           memWrite,
  input logic           regWrite
);

  logic opLegal;
  assign opLegal = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
                   (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                   (opcode == OPC_JUMP);

  a_r1_reset_fetch: assert property (@(posedge clk)
    !rstN |-> curState == 4'd0);

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rstN)
    curState == 4'd0 |=> curState == 4'd1);

  a_r3_decode_load: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd1 && opcode == OPC_LOAD) |=> curState == 4'd2);

  a_r4_store_path: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd2 && opcode == OPC_STORE) |=> curState == 4'd5);

  a_r5_load_read_to_wb: assert property (@(posedge clk) disable iff (!rstN)
    curState == 4'd3 |=> curState == 4'd4);

  a_r7_exec_to_wb: assert property (@(posedge clk) disable iff (!rstN)
    curState == 4'd6 |=> curState == 4'd7);

  a_r9_completion_return: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd4 || curState == 4'd5 || curState == 4'd7 ||
     curState == 4'd8 || curState == 4'd9) |=> curState == 4'd0);

  a_r10_illegal_return: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd1 && !opLegal) |=> curState == 4'd0);

  a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  a_r11_one_writer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcWriteCond, memWrite, regWrite}));

  a_r11_state_range: assert property (@(posedge clk) disable iff (!rstN)
    curState <= 4'd9);

endmodule

bind mcfsm_ctrl mcfsm_ctrl_chk #(
  .OPW(OPW), .OPC_RTYPE(OPC_RTYPE), .OPC_LOAD(OPC_LOAD),
  .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ), .OPC_JUMP(OPC_JUMP)
) chk_i (
  .clk(clk), .rstN(rstN), .opcode(opcode), .curState(curState),
  .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .memRead(memRead),
  .memWrite(memWrite), .regWrite(regWrite)
);

// File: tb/mcfsm_ctrl_tb_top.sv
module mcfsm_ctrl_tb_top;

  localparam logic [5:0] OP_R  = 6'b000000;
  localparam logic [5:0] OP_LW = 6'b100011;
  localparam logic [5:0] OP_SW = 6'b101011;
  localparam logic [5:0] OP_BQ = 6'b000100;
  localparam logic [5:0] OP_J  = 6'b000010;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] opcode = '0;
  logic [3:0] curState;
  logic pcWrite, pcWriteCond, iOrD, memRead, memWrite, irWrite, memToReg;
  logic [1:0] pcSrc, aluOp, aluSrcB;
  logic aluSrcA, regWrite, regDst;

  int checks = 0;
  int errors = 0;
  logic [3:0] expState = 4'd0;

  always #4 clk = ~clk;

  mcfsm_ctrl dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .curState(curState),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .iOrD(iOrD),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .memToReg(memToReg), .pcSrc(pcSrc), .aluOp(aluOp), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .regWrite(regWrite), .regDst(regDst)
  );

  // {pcWrite,pcWriteCond,iOrD,memRead,memWrite,irWrite,memToReg,pcSrc,aluOp,aluSrcA,aluSrcB,regWrite,regDst}
  wire [15:0] obsWord = {pcWrite, pcWriteCond, iOrD, memRead, memWrite, irWrite,
                         memToReg, pcSrc, aluOp, aluSrcA, aluSrcB, regWrite, regDst};

  function automatic logic isLegal(input logic [5:0] op);
    return op == OP_R || op == OP_LW || op == OP_SW || op == OP_BQ || op == OP_J;
  endfunction

  function automatic logic [3:0] modelNext(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == OP_LW || op == OP_SW) return 4'd2;
        if (op == OP_R)  return 4'd6;
        if (op == OP_BQ) return 4'd8;
        if (op == OP_J)  return 4'd9;
        return 4'd0;
      end
      4'd2: return (op == OP_LW) ? 4'd3 : 4'd5;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] mk(input logic pw, pwc, iod, mr, mw, irw, m2r,
                                     input logic [1:0] ps, ao, input logic asa,
                                     input logic [1:0] asb, input logic rw, rd);
    return {pw, pwc, iod, mr, mw, irw, m2r, ps, ao, asa, asb, rw, rd};
  endfunction

  function automatic logic [15:0] modelWord(input logic [3:0] s);
    case (s)
      4'd0: return mk(1,0,0,1,0,1,0, 2'b00, 2'b00, 0, 2'b01, 0, 0);
      4'd1: return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b11, 0, 0);
      4'd2: return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 1, 2'b10, 0, 0);
      4'd3: return mk(0,0,1,1,0,0,0, 2'b00, 2'b00, 0, 2'b00, 0, 0);
      4'd4: return mk(0,0,0,0,0,0,1, 2'b00, 2'b00, 0, 2'b00, 1, 0);
      4'd5: return mk(0,0,1,0,1,0,0, 2'b00, 2'b00, 0, 2'b00, 0, 0);
      4'd6: return mk(0,0,0,0,0,0,0, 2'b00, 2'b10, 1, 2'b00, 0, 0);
      4'd7: return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b00, 1, 1);
      4'd8: return mk(0,1,0,0,0,0,0, 2'b01, 2'b01, 1, 2'b00, 0, 0);
      4'd9: return mk(1,0,0,0,0,0,0, 2'b10, 2'b00, 0, 2'b00, 0, 0);
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Run one instruction from fetch back to fetch; returns at a negedge with state 0 expected.
  task automatic runInstr(input logic [5:0] op, input int expCycles, input string req);
    int n = 0;
    logic [3:0] nxt;
    logic noisy = 1'b0;
    do begin
      check({reqOf(expState), "_state"}, curState, expState);
      check({reqOf(expState), "_R11_word"}, obsWord, modelWord(expState));
      if (expState == 4'd1 && !isLegal(op))
        check("R10_no_write", {pcWrite, pcWriteCond, memWrite, regWrite}, 4'b0000);
      if (expState == 4'd0) opcode = op;
      else if (expState >= 4'd3) begin
        opcode = 6'($urandom);
        noisy = 1'b1;
      end
      nxt = modelNext(expState, opcode);
      n++;
      @(negedge clk);
      expState = nxt;
    end while (expState != 4'd0);
    check(req, n, expCycles);
    if (noisy) check("R12_noise_ignored", {curState, obsWord}, {4'd0, modelWord(4'd0)});
  endtask

  task automatic runKind(input int k);
    logic [5:0] bad;
    case (k)
      0: runInstr(OP_LW, 5, "R5_load_cycles");
      1: runInstr(OP_SW, 4, "R6_store_cycles");
      2: runInstr(OP_R,  4, "R7_rtype_cycles");
      3: runInstr(OP_BQ, 3, "R8_branch_cycles");
      4: runInstr(OP_J,  3, "R9_jump_cycles");
      default: begin
        do bad = 6'($urandom); while (isLegal(bad));
        runInstr(bad, 2, "R10_illegal_cycles");
      end
    endcase
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1_reset_state", curState, 4'd0);
    check("R1_reset_word", obsWord, modelWord(4'd0));
    rstN = 1'b1;
    expState = 4'd0;

    for (int k = 0; k < 6; k++) runKind(k);
    runInstr(6'b111111, 2, "R10_illegal_ones");

    // Asynchronous reset in the middle of a register-register instruction
    opcode = OP_R;
    repeat (2) @(negedge clk);
    check("R7_exec_before_reset", curState, 4'd6);
    rstN = 1'b0;
    #1;
    check("R1_async_reset", curState, 4'd0);
    @(negedge clk);
    check("R1_held_in_reset", curState, 4'd0);
    rstN = 1'b1;
    expState = 4'd0;

    // Reset in the middle of a load, at the memory read state
    opcode = OP_LW;
    repeat (3) @(negedge clk);
    check("R5_read_before_reset", curState, 4'd3);
    rstN = 1'b0;
    #1;
    check("R1_async_reset_load", {curState, obsWord}, {4'd0, modelWord(4'd0)});
    @(negedge clk);
    rstN = 1'b1;
    expState = 4'd0;

    for (int i = 0; i < 400; i++) runKind(int'($urandom_range(0, 5)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule